// File: doc/BRIEF.md
# Single-Precision Register Format Converter

The block moves 32-bit values between their memory image and the 64-bit layout they take in a floating-point register file. Three paths share one registered output stage. The load path expands a single-precision float into the wide register form. It rebiases the 8-bit exponent into an 11-bit field, with separate handling for zero and all-ones exponents. The store path gathers the wide form back into 32 bits. The longword path places a 64-bit integer into the register longword layout, with its two top bits and thirty low bits in split fields. It flags an input that does not fit in 32 signed bits.

A 2-bit operation code selects the path for each request. A request is accepted when `in_valid` is high. Its result appears one clock later with `out_valid` high for one cycle. The output holds its last value between results. The block does no arithmetic and no rounding.

Top module: `sfmt_conv`

## Requirements
- R1: Load (op 0): output bit 63 equals input bit 31, output bits 51:29 equal input bits 22:0, and output bits 28:0 are zero.
- R2: Load with a narrow exponent (input bits 30:23) from 128 to 254 gives a wide exponent (output bits 62:52) of {1, 000, narrow bits 6:0}.
- R3: Load with a narrow exponent of 255 gives a wide exponent of 0x7FF.
- R4: Load with a narrow exponent from 1 to 127 gives a wide exponent of 0x380 plus the narrow exponent.
- R5: Load with a narrow exponent of zero gives a wide exponent of zero.
- R6: Store (op 1): output bits 31:30 equal register bits 63:62, output bits 29:0 equal register bits 58:29, and output bits 63:32 are zero.
- R7: Longword (op 2): output bits 63:62 equal integer bits 31:30, output bits 58:29 equal integer bits 29:0, and all other output bits are zero.
- R8: On a longword result, `out_iov` and `out_ine` are both 1 exactly when the 64-bit input differs from the sign extension of its bits 31:0. On load and store results both flags are 0.
- R9: A request accepted with op 0, 1 or 2 gives `out_valid` high in the next cycle only. A request with op 3 gives no result.
- R10: While `rst` is high at a clock edge, `out_valid`, `out_data`, `out_iov` and `out_ine` become zero.
- R11: In cycles with no result, and after an op 3 request, `out_data` and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Path select: 0 load, 1 store, 2 longword, 3 reserved |
| mem_in | input | 32 | Memory image used by the load path |
| reg_in | input | 64 | Register image used by store, integer used by longword |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 64 | Converted value; the store result sits in bits 31:0 |
| out_iov | output | 1 | Longword integer overflow |
| out_ine | output | 1 | Longword inexact, set together with out_iov |

## Verification
The bound checker watches every cycle for the timing and shape of results. It checks that the strobe follows an accepted request by one cycle, that op 3 and idle cycles produce none, and that data holds between results. It also checks that the two flags always agree and appear only on longword results, and that the zero fields of load and longword results stay clear. The exponent remapping and the exact bit placement of each path depend on values, so only the bench scenarios can show them. Those scenarios cover exponents 0, 1, 127, 128, 254 and 255, and integers at both edges of the 32-bit signed range, and the bench compares each result against its own model of the requirements.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  parameter int NARROW_W = 32;
  parameter int WIDE_W   = 64;
  parameter int NEXP_W   = 8;
  parameter int WEXP_W   = 11;
  parameter int NFRAC_W  = NARROW_W - 1 - NEXP_W;
  parameter int WFRAC_W  = WIDE_W - 1 - WEXP_W;
  parameter int FRAC_SH  = WFRAC_W - NFRAC_W;
  parameter int LOW_W    = NARROW_W - 2;

  typedef enum logic [1:0] {
    SF_LOAD  = 2'd0,
    SF_STORE = 2'd1,
    SF_LWORD = 2'd2,
    SF_RSVD  = 2'd3
  } sf_op_e;
endpackage

// File: rtl/sfmt_exp_widen.sv
module sfmt_exp_widen #(
  parameter int NW = 8,
  parameter int WW = 11
) (
  input  logic [NW-1:0] nexp,
  output logic [WW-1:0] wexp
);
  localparam int GAP = WW - NW;
  logic          top;
  logic [NW-2:0] rest;

  assign top  = nexp[NW-1];
  assign rest = nexp[NW-2:0];

  always_comb begin
    if (top) begin
      if (&rest) wexp = {WW{1'b1}};
      else       wexp = {1'b1, {GAP{1'b0}}, rest};
    end else begin
      if (|rest) wexp = {1'b0, {GAP{1'b1}}, rest};
      else       wexp = '0;
    end
  end
endmodule

// File: rtl/sfmt_load_path.sv
module sfmt_load_path
  import sfmt_pkg::*;
(
  input  logic [NARROW_W-1:0] mem_word,
  output logic [WIDE_W-1:0]   wide_word
);
  logic [WEXP_W-1:0] wexp;

  sfmt_exp_widen #(.NW(NEXP_W), .WW(WEXP_W)) u_exp (
    .nexp (mem_word[NARROW_W-2 -: NEXP_W]),
    .wexp (wexp)
  );

  assign wide_word = {mem_word[NARROW_W-1], wexp,
                      mem_word[NFRAC_W-1:0], {FRAC_SH{1'b0}}};
endmodule

// File: rtl/sfmt_store_path.sv
module sfmt_store_path
  import sfmt_pkg::*;
(
  input  logic [WIDE_W-1:0]   wide_word,
  output logic [NARROW_W-1:0] mem_word
);
  logic unused_bits;
  assign unused_bits = ^{wide_word[WIDE_W-3:FRAC_SH+LOW_W], wide_word[FRAC_SH-1:0]};

  assign mem_word = {wide_word[WIDE_W-1 -: 2], wide_word[FRAC_SH +: LOW_W]};
endmodule

// File: rtl/sfmt_lword_path.sv
module sfmt_lword_path
  import sfmt_pkg::*;
(
  input  logic [WIDE_W-1:0] int_val,
  output logic [WIDE_W-1:0] wide_word,
  output logic              overflow
);
  localparam int MID_W = WIDE_W - 2 - LOW_W - FRAC_SH;

  assign wide_word = {int_val[NARROW_W-1 -: 2], {MID_W{1'b0}},
                      int_val[LOW_W-1:0], {FRAC_SH{1'b0}}};

  // fits when every upper bit repeats the narrow sign bit
  assign overflow = (int_val[WIDE_W-1:NARROW_W] !=
                     {(WIDE_W-NARROW_W){int_val[NARROW_W-1]}});
endmodule

// File: rtl/sfmt_conv.sv
module sfmt_conv
  import sfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic [NARROW_W-1:0] mem_in,
  input  logic [WIDE_W-1:0]   reg_in,
  output logic                out_valid,
  output logic [WIDE_W-1:0]   out_data,
  output logic                out_iov,
  output logic                out_ine
);
  logic [WIDE_W-1:0]   ld_word;
  logic [NARROW_W-1:0] st_word;
  logic [WIDE_W-1:0]   lw_word;
  logic                lw_ovf;
  logic                accept;
  logic [WIDE_W-1:0]   nxt_data;
  logic                nxt_flag;

  sfmt_load_path  u_load  (.mem_word(mem_in), .wide_word(ld_word));
  sfmt_store_path u_store (.wide_word(reg_in), .mem_word(st_word));
  sfmt_lword_path u_lword (.int_val(reg_in), .wide_word(lw_word), .overflow(lw_ovf));

  assign accept = in_valid && (sf_op_e'(op) != SF_RSVD);

  always_comb begin
    nxt_data = '0;
    nxt_flag = 1'b0;
    unique case (sf_op_e'(op))
      SF_LOAD:  nxt_data = ld_word;
      SF_STORE: nxt_data = {{(WIDE_W-NARROW_W){1'b0}}, st_word};
      SF_LWORD: begin
        nxt_data = lw_word;
        nxt_flag = lw_ovf;
      end
      default:  nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_iov   <= 1'b0;
      out_ine   <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data <= nxt_data;
        out_iov  <= nxt_flag;
        out_ine  <= nxt_flag;
      end
    end
  end
endmodule

// File: rtl/sfmt_conv_chk.sv
module sfmt_conv_chk
  import sfmt_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          op,
  input logic [NARROW_W-1:0] mem_in,
  input logic [WIDE_W-1:0]   reg_in,
  input logic                out_valid,
  input logic [WIDE_W-1:0]   out_data,
  input logic                out_iov,
  input logic                out_ine
);
  logic unused_chk;
  assign unused_chk = ^{mem_in, reg_in};

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'd3) |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op == 2'd3) |=> !out_valid);

  a_r8_flags_agree: assert property (@(posedge clk) disable iff (rst)
    out_iov == out_ine);

  a_r8_flag_only_lword: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'd2 && op != 2'd3) |=> !out_iov);

  a_r7_lword_zeros: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd2) |=> (out_data[61:59] == 3'b0 && out_data[28:0] == 29'b0));

  a_r1_load_low_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd0) |=> out_data[28:0] == 29'b0);

  a_r6_store_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd1) |=> out_data[63:32] == 32'b0);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op == 2'd3) |=> ($stable(out_data) && $stable(out_iov)));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_iov && !out_ine));
endmodule

bind sfmt_conv sfmt_conv_chk u_chk (.*);

// File: tb/sfmt_conv_test.sv
module sfmt_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] mem_in = '0;
  logic [63:0] reg_in = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_iov;
  logic        out_ine;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] data;
    logic        flag;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [63:0] last_data = '0;
  logic        last_flag = 1'b0;

  sfmt_conv uut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // bench model: rebias instead of bit surgery
  function automatic logic [63:0] model_load(input logic [31:0] m);
    int e;
    logic [10:0] w;
    e = int'(m[30:23]);
    if (e == 0) w = 11'd0;
    else if (e == 255) w = 11'd2047;
    else w = 11'(e + 896);
    return {m[31], w, m[22:0], 29'd0};
  endfunction

  function automatic logic [63:0] model_store(input logic [63:0] r);
    logic [63:0] v;
    v = ((r >> 62) << 30) | ((r >> 29) & 64'h3FFF_FFFF);
    return v;
  endfunction

  function automatic logic [63:0] model_lword(input logic [63:0] r);
    return (((r >> 30) & 64'h3) << 62) | ((r & 64'h3FFF_FFFF) << 29);
  endfunction

  function automatic logic model_ovf(input logic [63:0] r);
    longint s;
    s = longint'(r);
    return (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
  endfunction

  task automatic send(input logic [1:0] o, input logic [31:0] m,
                      input logic [63:0] r, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; mem_in = m; reg_in = r;
    e.due = cyc + 1;
    e.tag = tag;
    e.flag = 1'b0;
    case (o)
      2'd0: e.data = model_load(m);
      2'd1: e.data = model_store(r);
      default: begin
        e.data = model_lword(r);
        e.flag = model_ovf(r);
      end
    endcase
    if (o != 2'd3) sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results arrive
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R9 unexpected result", {63'd0, out_valid}, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, {e.tag, " R9 latency"}, 64'(cyc), 64'(e.due));
          check(out_data === e.data, {e.tag, " data"}, out_data, e.data);
          check(out_iov === e.flag && out_ine === e.flag, {e.tag, " R8 flags"},
                {62'd0, out_iov, out_ine}, {62'd0, e.flag, e.flag});
          last_data = e.data;
          last_flag = e.flag;
        end
      end
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data == 0 && !out_iov && !out_ine, "R10 reset state",
          out_data, 64'd0);
    rst = 1'b0;

    send(2'd0, 32'h3F80_0000, '0, "R4 load exp 127");
    send(2'd0, 32'hC020_0000, '0, "R2 load exp 128 negative");
    send(2'd0, 32'h7F7F_FFFF, '0, "R2 load exp 254");
    send(2'd0, 32'h0080_0001, '0, "R4 load exp 1");
    send(2'd0, 32'h0000_0000, '0, "R5 load zero");
    send(2'd0, 32'h8000_0001, '0, "R5 load denormal");
    send(2'd0, 32'h7F80_0000, '0, "R3 load infinity");
    send(2'd0, 32'hFFC1_2345, '0, "R3 load nan");
    send(2'd0, 32'h2AAA_AAAA, '0, "R1 load fraction pattern");
    send(2'd1, '0, 64'hC7FF_FFFF_E000_0000, "R6 store ones");
    send(2'd1, '0, 64'h4A5A_5A5A_5A5A_5A5A, "R6 store pattern");
    send(2'd1, '0, 64'h3800_0000_1FFF_FFFF, "R6 store ignored bits");
    send(2'd2, '0, 64'h0, "R7 lword zero");
    send(2'd2, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 lword minus one");
    send(2'd2, '0, 64'h0000_0000_7FFF_FFFF, "R8 lword max positive");
    send(2'd2, '0, 64'hFFFF_FFFF_8000_0000, "R8 lword min negative");
    send(2'd2, '0, 64'h0000_0000_8000_0000, "R8 lword overflow positive");
    send(2'd2, '0, 64'h0000_0001_0000_0000, "R8 lword overflow upper");
    send(2'd2, '0, 64'h8000_0000_1234_5678, "R8 lword overflow sign");
    idle(3);
    check(out_data === last_data && out_iov === last_flag, "R11 hold while idle",
          out_data, last_data);

    send(2'd3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9 reserved op");
    idle(2);
    check(out_valid === 1'b0, "R9 reserved gives no result", {63'd0, out_valid}, 64'd0);
    check(out_data === last_data && out_ine === last_flag, "R11 hold after reserved",
          out_data, last_data);

    send(2'd0, 32'h4049_0FDB, '0, "R1 load after gap");
    idle(1);
    send(2'd2, '0, 64'h0000_0000_C000_0001, "R7 lword top bits");
    idle(1);

    lf = 32'h1234_5679;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(2'(i % 3), lf, {lf ^ 32'hA5A5_0F0F, lf}, "R1 R6 R7 sweep");
    end
    idle(4);
    check(sb.size() == 0, "R9 all results delivered", 64'(sb.size()), 64'd0);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_data == 0 && !out_iov, "R10 reset after traffic",
          out_data, 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule